// File: doc/BRIEF.md
# Serial Memory Acknowledge Polling Controller

A two-wire serial memory does not answer on the bus while it commits a byte-load write to its nonvolatile array. This master-side sequencer finds out when that internal cycle is over. Once the host has ended the write with a STOP, it raises `start_i`. The controller then sends probes. Each probe is a START condition followed by the device address byte. It repeats probes until the memory acknowledges one of them.

The controller does not drive SCL or SDA itself. It sends commands to a bit-level bus engine over a valid/ready pair: START, STOP or SEND_BYTE. For every SEND_BYTE, the engine returns a one-cycle response that carries the acknowledge bit it sampled. The host sets the chip select bits, the probe direction, a limit on attempts and a continue flag. When the device acknowledges, the controller does one of two things. It can leave the bus held with no STOP, so the host can go straight on with its next read or write. Or it can release the bus with a STOP. When polling ends, the host gets a one-cycle ready pulse, the number of probes sent, and a timeout flag.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cmd_valid_o` and `ready_o` are low.
- R2: Every attempt issues command START (code 0) and then command SEND_BYTE (code 2). The SEND_BYTE data is {1,0,1,0,0,sel[1],sel[0],rw}, with bit 7 on the wire first and the direction bit in bit 0.
- R3: When a probe gets no acknowledge and the limit has not been reached, the next command is a new START. No STOP is sent between attempts.
- R4: When a probe is acknowledged and the continue flag is set, no STOP is issued. `ready_o` pulses and `timeout_o` stays low.
- R5: When a probe is acknowledged and the continue flag is clear, a STOP (code 1) is issued before `ready_o` pulses.
- R6: `attempts_o` equals the number of address probes sent in the finished polling run.
- R7: If the limit's worth of probes all get no acknowledge, STOP is issued and `ready_o` pulses with `timeout_o` high. A limit of 0 acts as 1.
- R8: `ready_o` is high for exactly one cycle per run. `busy_o` is high from the cycle after the start is accepted until the ready pulse ends.
- R9: `start_i` has no effect while `busy_o` is high. The settings latched at the accepted start stay in force for the whole run.
- R10: A command held with `cmd_valid_o` high and `cmd_ready_i` low keeps the same code and data until it is accepted.
- R11: After an accepted SEND_BYTE, no command is offered until the engine's response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (accepted while idle) |
| sel_i | input | 2 | Chip select bits placed in the address byte |
| rw_i | input | 1 | Direction bit of the probe byte |
| keep_i | input | 1 | 1: hold the bus after an acknowledge; 0: release it with STOP |
| max_att_i | input | CW | Attempt limit (0 acts as 1) |
| cmd_valid_o | output | 1 | Command offered to the bit engine |
| cmd_ready_i | input | 1 | Bit engine accepts the command |
| cmd_o | output | 2 | Command code: 0 START, 1 STOP, 2 SEND_BYTE |
| cmd_data_o | output | 8 | Byte for SEND_BYTE |
| rsp_valid_i | input | 1 | Response to a SEND_BYTE, one cycle |
| rsp_ack_i | input | 1 | Device acknowledged the byte |
| busy_o | output | 1 | Polling run in progress |
| ready_o | output | 1 | One-cycle pulse when the run ends |
| timeout_o | output | 1 | Run ended without an acknowledge (valid with ready_o) |
| attempts_o | output | CW | Probes sent in the run |

## Verification
The assertions assume the bit engine behaves well. It returns exactly one response per accepted SEND_BYTE, never sends a response at any other time, and answers START and STOP through the handshake alone. The bench models the engine so that it stays inside these rules. It pulses `rsp_valid_i` only after it has logged a SEND_BYTE transfer, waits a random 0 to 3 cycles before doing so, and lowers `cmd_ready_i` at random. A scripted count of refusals decides whether each probe is acknowledged. The bench raises `start_i` again only while a run is busy, which exercises the rule that such a start is ignored.

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    sel_i,
  input  logic          rw_i,
  input  logic          keep_i,
  input  logic [CW-1:0] max_att_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [1:0]    cmd_o,
  output logic [7:0]    cmd_data_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_ack_i,
  output logic          busy_o,
  output logic          ready_o,
  output logic          timeout_o,
  output logic [CW-1:0] attempts_o
);
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_SEND  = 2'd2;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {IDLE, PUT_START, PUT_ADDR, AWAIT, PUT_STOP, FINISH} state_t;

  state_t        st;
  logic [1:0]    sel_q;
  logic          rw_q, keep_q, miss_q;
  logic [CW-1:0] limit_q, cnt;

  assign cmd_valid_o = (st == PUT_START) || (st == PUT_ADDR) || (st == PUT_STOP);
  assign cmd_o       = (st == PUT_STOP) ? OP_STOP : (st == PUT_ADDR) ? OP_SEND : OP_START;
  assign cmd_data_o  = {DEV_TYPE, 1'b0, sel_q, rw_q};
  assign busy_o      = (st != IDLE);
  assign ready_o     = (st == FINISH);
  assign timeout_o   = ready_o & miss_q;
  assign attempts_o  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      sel_q   <= '0;
      rw_q    <= 1'b0;
      keep_q  <= 1'b0;
      miss_q  <= 1'b0;
      limit_q <= '0;
      cnt     <= '0;
    end else begin
      case (st)
        IDLE: if (start_i) begin
          sel_q   <= sel_i;
          rw_q    <= rw_i;
          keep_q  <= keep_i;
          limit_q <= max_att_i;
          cnt     <= '0;
          miss_q  <= 1'b0;
          st      <= PUT_START;
        end
        PUT_START: if (cmd_ready_i) st <= PUT_ADDR;
        PUT_ADDR: if (cmd_ready_i) begin
          cnt <= cnt + 1'b1;
          st  <= AWAIT;
        end
        AWAIT: if (rsp_valid_i) begin
          if (rsp_ack_i)            st <= keep_q ? FINISH : PUT_STOP;
          else if (cnt >= limit_q) begin
            miss_q <= 1'b1;
            st     <= PUT_STOP;
          end else                  st <= PUT_START;
        end
        PUT_STOP: if (cmd_ready_i) st <= FINISH;
        FINISH:   st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ack_poll_seq_chk.sv
module ack_poll_seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [1:0]    cmd_o,
  input logic [7:0]    cmd_data_o,
  input logic          busy_o,
  input logic          ready_o,
  input logic          timeout_o,
  input logic [CW-1:0] attempts_o
);
  // R10
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_data_o));
  // R11
  wait_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_ready_i && cmd_o == 2'd2 |=> !cmd_valid_o);
  // R8
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);
  // R7
  timeout_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> ready_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_valid_o && !ready_o);
  // R6
  attempts_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> attempts_o != '0);
  // R2
  addr_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_o == 2'd2 |-> cmd_data_o[7:3] == 5'b10100);
endmodule

bind ack_poll_seq ack_poll_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_o(cmd_o), .cmd_data_o(cmd_data_o), .busy_o(busy_o), .ready_o(ready_o),
  .timeout_o(timeout_o), .attempts_o(attempts_o)
);

// File: tb/ack_poll_seq_bench.sv
module ack_poll_seq_bench;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rw_i = 1'b0, keep_i = 1'b0;
  logic [1:0] sel_i = '0;
  logic [CW-1:0] max_att_i = '0;
  logic cmd_valid_o, cmd_ready_i = 1'b0, rsp_valid_i = 1'b0, rsp_ack_i = 1'b0;
  logic [1:0] cmd_o;
  logic [7:0] cmd_data_o;
  logic busy_o, ready_o, timeout_o;
  logic [CW-1:0] attempts_o;

  ack_poll_seq #(.CW(CW)) u_ack_poll_seq (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int nacks_left = 0, nlog = 0, rdy_cnt = 0;
  int log_c [0:63];
  int log_d [0:63];
  int got_att = 0, got_to = 0;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic ck(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int addr_byte(input int s, input int r);
    return (32'hA0 | (s << 1) | r);
  endfunction

  initial begin : engine
    bit pv = 0, pr = 0, waiting = 0;
    int pc = 0, pd = 0, pend = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pv = 0; pr = 0; waiting = 0;
        cmd_ready_i = 0; rsp_valid_i = 0;
      end else begin
        if (pv && pr) begin
          if (nlog < 64) begin log_c[nlog] = pc; log_d[nlog] = pd; end
          nlog++;
          if (pc == 2) begin waiting = 1; pend = $urandom % 4; end
        end
        rsp_valid_i = 0;
        if (waiting) begin
          if (pend == 0) begin
            rsp_valid_i = 1;
            rsp_ack_i = (nacks_left == 0);
            if (nacks_left > 0) nacks_left--;
            waiting = 0;
          end else pend--;
        end
        if (ready_o) begin
          rdy_cnt++;
          got_att = int'(attempts_o);
          got_to = int'(timeout_o);
        end
        cmd_ready_i = ($urandom % 3) != 0;
        pv = cmd_valid_o; pr = cmd_ready_i; pc = int'(cmd_o); pd = int'(cmd_data_o);
      end
    end
  end

  task automatic run_case(input int s, input int r, input int kp, input int mx, input int nk);
    int lim, probes, acked, n;
    @(negedge clk);
    sel_i = s[1:0]; rw_i = r[0]; keep_i = kp[0]; max_att_i = mx[CW-1:0];
    nacks_left = nk; nlog = 0; rdy_cnt = 0;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    ck(busy_o == 1'b1, "R8 busy after start", int'(busy_o), 1);
    @(negedge clk);
    if (busy_o) begin
      sel_i = ~s[1:0]; rw_i = ~r[0]; keep_i = ~kp[0]; max_att_i = 8'd1;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    n = 0;
    while (rdy_cnt == 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    lim = (mx == 0) ? 1 : mx;
    acked = (nk < lim);
    probes = acked ? nk + 1 : lim;
    ck(rdy_cnt == 1, "R8 ready pulse count", rdy_cnt, 1);
    ck(busy_o == 1'b0, "R8 idle after run", int'(busy_o), 0);
    ck(got_att == probes, "R6 attempts", got_att, probes);
    ck(got_to == !acked, "R7 timeout flag", got_to, int'(!acked));
    n = 2 * probes + ((acked && kp != 0) ? 0 : 1);
    ck(nlog == n, acked ? (kp != 0 ? "R4 command count" : "R5 command count") : "R7 command count", nlog, n);
    for (int i = 0; i < 2 * probes && i < nlog && i < 64; i++) begin
      if (i % 2 == 0) ck(log_c[i] == 0, "R3 START begins attempt", log_c[i], 0);
      else begin
        ck(log_c[i] == 2, "R2 SEND follows START", log_c[i], 2);
        ck(log_d[i] == addr_byte(s, r), "R9 R2 address byte", log_d[i], addr_byte(s, r));
      end
    end
    if (n == 2 * probes + 1 && nlog == n && n <= 64)
      ck(log_c[n-1] == 1, acked ? "R5 closing STOP" : "R7 closing STOP", log_c[n-1], 1);
  endtask

  initial begin : wd
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    ck(busy_o == 0, "R1 busy at reset", int'(busy_o), 0);
    ck(cmd_valid_o == 0, "R1 no command at reset", int'(cmd_valid_o), 0);
    ck(ready_o == 0, "R1 no ready at reset", int'(ready_o), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_case(0, 0, 1, 4, 0);
    run_case(3, 1, 0, 4, 0);
    run_case(1, 0, 0, 5, 3);
    run_case(2, 1, 1, 5, 4);
    run_case(1, 1, 0, 5, 5);
    run_case(2, 0, 1, 0, 0);
    run_case(3, 0, 1, 0, 2);
    run_case(0, 1, 1, 3, 7);
    for (int k = 0; k < 30; k++)
      run_case($urandom % 4, $urandom % 2, $urandom % 2, $urandom % 7, $urandom % 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule